// File: doc/BRIEF.md
# Receive Buffer Descriptor Manager

This block steers received Ethernet frames into a ring of memory buffers. Each buffer is described by a two-word descriptor. The first word holds the buffer's word address and two flag bits; the second word holds the receive status. The block walks the ring from a programmed base address. It fetches a descriptor and checks whether software still owns the buffer. It then counts the incoming frame bytes into that buffer and moves on to the next descriptor whenever the buffer fills. When a buffer is finished, the block writes that buffer's status word and then marks the descriptor as used.

The MAC side delivers one frame byte per valid/ready beat, with a last flag on the final byte. For every byte it accepts, the block reports the byte address at which the payload path should store that byte. Moving the payload itself is not part of this block. Descriptor reads and writes leave through a single valid/ready request port. Read data returns on a separate response strobe, and only one read is ever outstanding.

Back-pressure works as follows. The block raises `in_ready` only while it is filling a buffer or discarding a dropped frame. Once `in_valid` is raised, it must stay high with `in_last` unchanged until the beat is accepted. Once `mem_req_valid` is raised, it stays high with address, direction and write data unchanged until `mem_req_ready` is seen.

Top module: `rx_desc_mgr`

## Requirements
- R1: After reset, the first descriptor is fetched from `cfg_ring_base` with bits 2:0 forced to zero. Each descriptor that is consumed moves the queue pointer forward by 8 bytes. Only word 0 (at the pointer) is read, and only at word-aligned addresses.
- R2: Once a descriptor whose word 0 bit 1 (wrap) is set has been consumed, the next fetch goes back to the ring base.
- R3: If word 0 bit 0 (used) is already 1 when a descriptor is fetched, the remainder of the frame is accepted and discarded. `buf_unavail` pulses for one cycle and nothing is written for that descriptor. The queue pointer does not advance, so the next frame fetches the same descriptor again.
- R4: A buffer holds `cfg_buf_units`×64 bytes, where a value of 0 means 256 units (16384 bytes). The first buffer of a frame starts `cfg_rx_offset` bytes past its word address and is that many bytes shorter. `byte_addr` shows the address of the byte being accepted.
- R5: When a buffer fills before the frame ends, its status word is written as 0, except that bit 14 (start of frame) is set if it is the frame's first buffer.
- R6: The last buffer of a frame gets a status word with bit 15 (end of frame) set, bit 14 set if it is also the first buffer, and bits 12:0 holding the total frame length in bytes. A frame whose final byte exactly fills a buffer ends in that buffer.
- R7: For each finished buffer, the status word (pointer+4) is written before word 0. Word 0 is written back as the fetched address and wrap bit with bit 0 set.
- R8: Under back-pressure, a pending memory request holds its address, direction and data unchanged. `in_ready` is low while a memory request is pending and while the block is idle.
- R9: `frame_done` pulses for one cycle, in the cycle after the final buffer's word 0 write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | 32 | Byte address of the first descriptor |
| cfg_buf_units | input | 8 | Buffer size in 64-byte units, 0 = 256 |
| cfg_rx_offset | input | 2 | Start offset in bytes of a frame's first buffer |
| in_valid | input | 1 | A frame byte is offered |
| in_ready | output | 1 | The offered byte is taken this cycle |
| in_last | input | 1 | The offered byte ends the frame |
| byte_addr | output | 32 | Destination address of the byte being accepted |
| mem_req_valid | output | 1 | Descriptor access request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the descriptor word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 32 | Read data |
| frame_done | output | 1 | One-cycle pulse when a frame has been fully written back |
| buf_unavail | output | 1 | One-cycle pulse when a fetched descriptor was already used |

## Verification
The checker takes several things as given about the inputs. Each read request receives exactly one response, at least one cycle after it was accepted, and no response arrives unasked. The ring base is 8-byte aligned. The configuration inputs stay constant while a frame is in progress. The bench keeps to these rules in the following way. Its memory model answers every accepted read on the next cycle and varies `mem_req_ready` at random. The offered byte is held until it is accepted. Descriptors are re-armed and the configuration is changed only after the previous frame has completed or been dropped.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
  localparam int DW         = 32;
  localparam int USED_BIT   = 0;
  localparam int WRAP_BIT   = 1;
  localparam int SOF_BIT    = 14;
  localparam int EOF_BIT    = 15;
  localparam int LEN_W      = 13;
  localparam int DESC_BYTES = 8;
  localparam int STAT_OFS   = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_WAIT, S_FILL, S_WSTAT, S_WADDR, S_DROP
  } rdm_state_t;

  function automatic logic [DW-1:0] mk_status(input logic first, input logic last,
                                              input logic [LEN_W-1:0] len);
    logic [DW-1:0] s;
    s = '0;
    s[SOF_BIT] = first;
    if (last) begin
      s[EOF_BIT]     = 1'b1;
      s[LEN_W-1:0]   = len;
    end
    return s;
  endfunction
endpackage

// File: rtl/rdm_qptr.sv
module rdm_qptr #(
  parameter int AW   = 32,
  parameter int STEP = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic          advance,
  input  logic          wrap,
  output logic [AW-1:0] ptr
);
  localparam int ALN = $clog2(STEP);

  logic          started;
  logic [AW-1:0] cur;
  logic [AW-1:0] base_al;

  assign base_al = {base[AW-1:ALN], {ALN{1'b0}}};
  assign ptr     = started ? cur : base_al;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cur     <= '0;
    end else if (advance) begin
      started <= 1'b1;
      cur     <= wrap ? base_al : ptr + AW'(STEP);
    end
  end
endmodule

// File: rtl/rdm_acct.sv
module rdm_acct #(
  parameter int UNIT_W    = 8,
  parameter int UNIT_LOG2 = 6,
  parameter int AW        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              first,
  input  logic [1:0]        offset,
  input  logic [UNIT_W-1:0] units,
  input  logic [AW-1:0]     start,
  input  logic              inc,
  output logic              last_slot,
  output logic [AW-1:0]     addr
);
  localparam int CNT_W = UNIT_W + 1 + UNIT_LOG2;

  logic [UNIT_W:0]    u_eff;
  logic [CNT_W-1:0]   size;
  logic [CNT_W-1:0]   skip;
  logic [CNT_W-1:0]   cap;
  logic [CNT_W-1:0]   fill;
  logic [AW-1:0]      base;

  always_comb begin
    u_eff = (units == '0) ? {1'b1, {UNIT_W{1'b0}}} : {1'b0, units};
    size  = {u_eff, {UNIT_LOG2{1'b0}}};
    skip  = first ? CNT_W'(offset) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap  <= '0;
      fill <= '0;
      base <= '0;
    end else if (load) begin
      cap  <= size - skip;
      fill <= '0;
      base <= start + AW'(skip);
    end else if (inc) begin
      fill <= fill + 1'b1;
    end
  end

  assign last_slot = (fill + 1'b1) == cap;
  assign addr      = base + AW'(fill);
endmodule

// File: rtl/rx_desc_mgr.sv
module rx_desc_mgr
  import rdm_pkg::*;
#(
  parameter int UNIT_W    = 8,
  parameter int UNIT_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     cfg_ring_base,
  input  logic [UNIT_W-1:0] cfg_buf_units,
  input  logic [1:0]        cfg_rx_offset,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  output logic [DW-1:0]     byte_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [DW-1:0]     mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              frame_done,
  output logic              buf_unavail
);
  rdm_state_t        state, state_n;
  logic [DW-3:0]     buf_word;
  logic              buf_wrap;
  logic              first_buf;
  logic              is_final;
  logic [LEN_W-1:0]  flen;
  logic              done_q, bna_q;

  logic [DW-1:0]     qptr;
  logic              q_adv;
  logic              acct_load, acct_inc, acct_last;
  logic              accept, fetch_ok, fetch_used;

  assign accept     = in_valid && in_ready;
  assign fetch_ok   = (state == S_WAIT) && mem_rsp_valid && !mem_rsp_data[USED_BIT];
  assign fetch_used = (state == S_WAIT) && mem_rsp_valid &&  mem_rsp_data[USED_BIT];
  assign acct_load  = fetch_ok;
  assign acct_inc   = (state == S_FILL) && in_valid;
  assign q_adv      = (state == S_WADDR) && mem_req_ready;

  rdm_qptr #(.AW(DW), .STEP(DESC_BYTES)) u_qptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .base    (cfg_ring_base),
    .advance (q_adv),
    .wrap    (buf_wrap),
    .ptr     (qptr)
  );

  rdm_acct #(.UNIT_W(UNIT_W), .UNIT_LOG2(UNIT_LOG2), .AW(DW)) u_acct (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acct_load),
    .first     (first_buf),
    .offset    (cfg_rx_offset),
    .units     (cfg_buf_units),
    .start     ({mem_rsp_data[DW-1:2], 2'b00}),
    .inc       (acct_inc),
    .last_slot (acct_last),
    .addr      (byte_addr)
  );

  assign in_ready = (state == S_FILL) || (state == S_DROP);

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = qptr;
    mem_req_wdata = {buf_word, buf_wrap, 1'b1};
    unique case (state)
      S_FETCH: mem_req_valid = 1'b1;
      S_WSTAT: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = qptr + DW'(STAT_OFS);
        mem_req_wdata = mk_status(first_buf, is_final, flen);
      end
      S_WADDR: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_n = state;
    unique case (state)
      S_IDLE:  if (in_valid) state_n = S_FETCH;
      S_FETCH: if (mem_req_ready) state_n = S_WAIT;
      S_WAIT: begin
        if (fetch_ok)        state_n = S_FILL;
        else if (fetch_used) state_n = S_DROP;
      end
      S_FILL:  if (accept && (in_last || acct_last)) state_n = S_WSTAT;
      S_WSTAT: if (mem_req_ready) state_n = S_WADDR;
      S_WADDR: if (mem_req_ready) state_n = is_final ? S_IDLE : S_FETCH;
      S_DROP:  if (accept && in_last) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      buf_word  <= '0;
      buf_wrap  <= 1'b0;
      first_buf <= 1'b1;
      is_final  <= 1'b0;
      flen      <= '0;
      done_q    <= 1'b0;
      bna_q     <= 1'b0;
    end else begin
      state  <= state_n;
      done_q <= q_adv && is_final;
      bna_q  <= fetch_used;
      if (state == S_IDLE && in_valid) begin
        first_buf <= 1'b1;
        flen      <= '0;
      end
      if (fetch_ok) begin
        buf_word <= mem_rsp_data[DW-1:2];
        buf_wrap <= mem_rsp_data[WRAP_BIT];
      end
      if (state == S_FILL && accept) begin
        flen     <= flen + 1'b1;
        is_final <= in_last;
      end
      if (q_adv) first_buf <= 1'b0;
    end
  end

  assign frame_done  = done_q;
  assign buf_unavail = bna_q;
endmodule

// File: rtl/rdm_chk.sv
module rdm_chk
  import rdm_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [DW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          frame_done,
  input logic          buf_unavail
);
  logic [DW-1:0] sof_mask;
  assign sof_mask = DW'(1) << SOF_BIT;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_write) && $stable(mem_req_wdata))); // R8

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !mem_req_valid); // R8

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00)); // R1

  AST_RD_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> !mem_req_addr[2]); // R1

  AST_USED_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_req_addr[2]) |-> mem_req_wdata[USED_BIT]); // R7

  AST_MID_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_addr[2] && !mem_req_wdata[EOF_BIT])
      |-> ((mem_req_wdata & ~sof_mask) == '0)); // R5

  AST_DONE_AFTER_W0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(mem_req_valid && mem_req_ready && mem_req_write && !mem_req_addr[2])); // R9

  AST_BNA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_unavail |-> (!mem_req_valid && !frame_done)); // R3
endmodule

bind rx_desc_mgr rdm_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_ready      (in_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .frame_done    (frame_done),
  .buf_unavail   (buf_unavail)
);

// File: tb/rx_desc_mgr_test.sv
module rx_desc_mgr_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int ND  = 6;
  localparam int SOF = 14;
  localparam int EOF = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_ring_base = BASE;
  logic [7:0]  cfg_buf_units = 8'd1;
  logic [1:0]  cfg_rx_offset = 2'd0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [31:0] byte_addr;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        frame_done, buf_unavail;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_mgr uut (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_buf_units(cfg_buf_units),
    .cfg_rx_offset(cfg_rx_offset), .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
    .byte_addr(byte_addr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .frame_done(frame_done), .buf_unavail(buf_unavail));

  int checks = 0, errors = 0;
  int done_cnt = 0, bna_cnt = 0;
  logic [31:0] mem [0:2*ND-1];
  logic [31:0] sh  [0:2*ND-1];
  bit          stat_seen [0:ND-1];
  int          p_model = 0;
  longint      exp_baddr [0:2047];
  bit          exp_done, exp_bna;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: one-cycle read latency, logs write order
  always @(posedge clk) begin
    logic [31:0] off;
    int idx;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      off = mem_req_addr - BASE;
      idx = int'(off[31:2]);
      if (off >= 32'(8*ND)) begin
        chk(1'b0, "R1 address in ring", longint'(mem_req_addr), longint'(BASE));
      end else if (mem_req_write) begin
        if (!off[2]) begin
          chk(stat_seen[idx/2], "R7 status before word0", 0, 1);
          stat_seen[idx/2] = 1'b0;
        end else stat_seen[idx/2] = 1'b1;
        mem[idx] = mem_req_wdata;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[idx];
      end
    end
  end

  always @(negedge clk) begin
    mem_req_ready <= ($urandom % 4) != 0;
    if (rst_n && frame_done)  done_cnt++;
    if (rst_n && buf_unavail) bna_cnt++;
  end

  task automatic arm(input bit allow_used);
    for (int d = 0; d < ND; d++) begin
      logic [31:0] w;
      w = 32'h0000_8000 + 32'(d) * 32'h4000;
      if (d == ND-1) w[1] = 1'b1;
      if (allow_used && ($urandom % 8 == 0)) w[0] = 1'b1;
      mem[2*d] = w; sh[2*d] = w;
      mem[2*d+1] = '0; sh[2*d+1] = '0;
      stat_seen[d] = 1'b0;
    end
  endtask

  function automatic int cap_of(input bit first);
    int u;
    u = (cfg_buf_units == 0) ? 256 : int'(cfg_buf_units);
    return u*64 - (first ? int'(cfg_rx_offset) : 0);
  endfunction

  task automatic model(input int len);
    int rem, k, cap, n;
    bit first;
    logic [31:0] w0, start;
    rem = len; k = 0; first = 1; exp_done = 0; exp_bna = 0;
    while (1) begin
      w0 = sh[2*p_model];
      if (w0[0]) begin
        exp_bna = 1;
        for (int j = k; j < len; j++) exp_baddr[j] = -1;
        break;
      end
      cap = cap_of(first);
      start = {w0[31:2], 2'b00} + (first ? 32'(cfg_rx_offset) : 32'd0);
      n = (rem <= cap) ? rem : cap;
      for (int j = 0; j < n; j++) exp_baddr[k+j] = longint'(start + 32'(j));
      k += n;
      if (rem <= cap) begin
        sh[2*p_model+1] = (32'd1 << EOF) | (first ? (32'd1 << SOF) : 32'd0) | 32'(len % 8192);
      end else begin
        sh[2*p_model+1] = first ? (32'd1 << SOF) : 32'd0;
      end
      sh[2*p_model] = w0 | 32'd1;
      p_model = w0[1] ? 0 : p_model + 1;
      first = 0;
      if (rem <= cap) begin exp_done = 1; break; end
      rem -= n;
    end
  endtask

  task automatic run_frame(input int len, input string tag);
    int d0, b0, bad;
    d0 = done_cnt; b0 = bna_cnt;
    model(len);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_last = (k == len-1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      if (exp_baddr[k] >= 0)
        chk(byte_addr == exp_baddr[k][31:0], "R4 byte address", longint'(byte_addr), exp_baddr[k]);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    if (exp_done) begin
      for (int t = 0; t < 100 && done_cnt == d0; t++) @(negedge clk);
    end else repeat (4) @(negedge clk);
    chk(done_cnt - d0 == int'(exp_done), "R9 frame_done count", done_cnt - d0, exp_done);
    chk(bna_cnt - b0 == int'(exp_bna), "R3 buf_unavail count", bna_cnt - b0, exp_bna);
    chk(in_ready == 1'b0, "R8 in_ready low when idle", in_ready, 0);
    bad = -1;
    for (int i = 0; i < 2*ND; i++) if (bad < 0 && mem[i] !== sh[i]) bad = i;
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s descriptor word %0d", tag, bad), longint'(mem[bad]), longint'(sh[bad]));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=complete");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    arm(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b0, "R8 reset in_ready", in_ready, 0);
    chk(mem_req_valid == 1'b0, "R1 reset no request", mem_req_valid, 0);
    chk(frame_done == 1'b0 && buf_unavail == 1'b0, "R9 reset pulses low", frame_done, 0);

    run_frame(64,  "R1 R6 exact-fill single buffer at ring base");
    run_frame(65,  "R5 R6 two buffers");
    cfg_rx_offset = 2'd3;
    run_frame(61,  "R4 R6 offset-shortened single buffer");
    run_frame(62,  "R4 R5 offset spill into second buffer");
    run_frame(130, "R2 R5 wrap to ring base");
    cfg_rx_offset = 2'd0;
    arm(1'b0);
    mem[2*p_model][0] = 1'b1; sh[2*p_model][0] = 1'b1;
    run_frame(40,  "R3 used descriptor drops frame");
    run_frame(10,  "R3 pointer held after drop");
    arm(1'b0);
    begin
      int nx;
      nx = (p_model == ND-1) ? 0 : p_model + 1;
      mem[2*nx][0] = 1'b1; sh[2*nx][0] = 1'b1;
    end
    run_frame(100, "R3 R5 drop after first buffer");
    arm(1'b0);
    cfg_buf_units = 8'd0; cfg_rx_offset = 2'd2;
    run_frame(300, "R4 R6 zero units means 16 KB");
    for (int f = 0; f < 40; f++) begin
      arm(1'b1);
      cfg_buf_units = 8'(1 + $urandom % 3);
      cfg_rx_offset = 2'($urandom % 4);
      run_frame(1 + int'($urandom % 300), "R7 random frame writeback");
    end
    repeat (5) @(negedge clk);
    summary();
  end
endmodule